// File: doc/BRIEF.md
# SPI Flash Region Erase Sequencer

This block sits on the host side of an SPI serial flash and wipes one region of it on request. A requester gives an erase size and a 24-bit address. The size is either a 4 KB sector or a 32 KB block. The sequencer then runs three kinds of bus transactions, each in its own chip-select frame:

- a write-enable command;
- the erase command, carrying the address;
- repeated status reads, until the flash reports that it is idle.

It then pulses a completion strobe. The requester's interface is a single-cycle request with a busy flag. The flag stays high for the whole operation.

The serial clock is derived from the system clock by an even divider and runs in SPI mode 0, most significant bit first. Block erase has two accepted opcodes, and a configuration input chooses which one is sent. A programmable poll budget bounds the wait. If the flash still reports busy after that many status reads, the operation finishes with an error flag.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is held, `cs_n` is 1, `sck` is 0, and `busy`, `done` and `err` are 0.
- R2: `req_valid` sampled high while `busy` is low accepts the request, and `busy` is 1 from the next cycle on. `busy` stays 1 until the cycle in which `done` is 1. In that cycle `busy` is 0, and `done` lasts exactly one cycle.
- R3: The first frame of every operation carries exactly 8 bits, the write-enable opcode 0x06.
- R4: The second frame carries exactly 32 bits: an opcode byte followed by `req_addr[23:0]`, MSB first. The opcode is 0x20 when `req_block`=0, regardless of `req_alt`. When `req_block`=1 it is 0x52 if `req_alt`=0 and 0xD8 if `req_alt`=1.
- R5: Each later frame is a 16-bit status read: 0x05 is sent, then 8 bits are read back while `mosi` stays 0. Bit 0 of the returned byte, which is the last bit received, is the busy flag. A new status frame follows as long as that flag is 1 and the budget is not used up.
- R6: SPI mode 0 framing applies. `sck` is 0 whenever `cs_n` is 1, and `mosi` changes only while `sck` is low.
- R7: Each high phase of `sck` lasts DIV/2 system clocks (2 with the default DIV=4).
- R8: Between any two frames, `cs_n` stays high for at least 2 system clocks.
- R9: If `poll_limit` status reads (a limit of 0 counts as 1) all return busy=1, no further status read is made. The operation then ends with `done`=1 and `err`=1. Otherwise `err` is 0 at `done`.
- R10: A `req_valid` pulse while `busy` is 1 is ignored: the frames and the result of the operation in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Erase request strobe |
| req_block | input | 1 | 0 = 4 KB sector erase, 1 = 32 KB block erase |
| req_alt | input | 1 | Block opcode select: 0 = 0x52, 1 = 0xD8 |
| req_addr | input | 24 | Flash address of the region to erase |
| poll_limit | input | PLW | Maximum number of status reads per operation |
| busy | output | 1 | High from request accept until done |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll budget exhausted; valid with done |
| sck | output | 1 | SPI serial clock (mode 0) |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is the boundary of the poll budget. The flash must report busy for exactly as many status reads as the budget allows, one fewer, or more. The bench's flash model is told before each request how many status reads should return busy. The sweep covers every pairing of that count (0 to 3) with every budget (0 to 4), so both sides of the timeout edge and the zero-budget case are all exercised. Requests injected in the middle of operations probe the ignore rule.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam logic [7:0] OPC_WEN      = 8'h06;
  localparam logic [7:0] OPC_SECTOR   = 8'h20;
  localparam logic [7:0] OPC_BLOCK_A  = 8'h52;
  localparam logic [7:0] OPC_BLOCK_B  = 8'hD8;
  localparam logic [7:0] OPC_STATUS   = 8'h05;

  localparam int FRAME_W   = 32;
  localparam int NBITS_W   = 6;

  typedef enum logic [2:0] {
    SEQ_IDLE    = 3'd0,
    SEQ_WEN_GO  = 3'd1,
    SEQ_WEN_WT  = 3'd2,
    SEQ_ERS_GO  = 3'd3,
    SEQ_ERS_WT  = 3'd4,
    SEQ_POL_GO  = 3'd5,
    SEQ_POL_WT  = 3'd6
  } seq_state_t;

endpackage

// File: rtl/fes_frame_shifter.sv
module fes_frame_shifter
  import flash_erase_pkg::*;
#(
  parameter int DIV = 4,
  parameter int GAP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NBITS_W-1:0] nbits,
  input  logic [FRAME_W-1:0] tx,
  input  logic               miso,
  output logic               ready,
  output logic               fin,
  output logic               rx_last,
  output logic               sck,
  output logic               cs_n,
  output logic               mosi
);

  localparam int HALF = DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int GW   = $clog2(GAP + 1);
  localparam logic [DW-1:0] DIV_TOP = DW'(HALF - 1);
  localparam logic [GW-1:0] GAP_LD  = GW'(GAP);

  logic               act_q, act_d;
  logic               sck_q, sck_d;
  logic               cs_q, cs_d;
  logic               fin_q, fin_d;
  logic               rx_q, rx_d;
  logic [DW-1:0]      div_q, div_d;
  logic [NBITS_W-1:0] bit_q, bit_d;
  logic [NBITS_W-1:0] len_q, len_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [GW-1:0]      gap_q, gap_d;
  logic               tick;

  assign tick = (div_q == DIV_TOP);

  always_comb begin
    act_d = act_q;
    sck_d = sck_q;
    cs_d  = cs_q;
    fin_d = 1'b0;
    rx_d  = rx_q;
    div_d = div_q;
    bit_d = bit_q;
    len_d = len_q;
    sh_d  = sh_q;
    gap_d = gap_q;
    if (!act_q) begin
      if (gap_q != '0) begin
        gap_d = gap_q - 1'b1;
      end else if (start) begin
        act_d = 1'b1;
        cs_d  = 1'b0;
        sh_d  = tx;
        len_d = nbits;
        bit_d = '0;
        div_d = '0;
        sck_d = 1'b0;
      end
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!sck_q) begin
          sck_d = 1'b1;
          rx_d  = miso;
        end else begin
          sck_d = 1'b0;
          if (bit_q == len_q - 1'b1) begin
            act_d = 1'b0;
            cs_d  = 1'b1;
            fin_d = 1'b1;
            gap_d = GAP_LD;
          end else begin
            bit_d = bit_q + 1'b1;
            sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      fin_q <= 1'b0;
      rx_q  <= 1'b0;
      div_q <= '0;
      bit_q <= '0;
      len_q <= '0;
      sh_q  <= '0;
      gap_q <= '0;
    end else begin
      act_q <= act_d;
      sck_q <= sck_d;
      cs_q  <= cs_d;
      fin_q <= fin_d;
      rx_q  <= rx_d;
      div_q <= div_d;
      bit_q <= bit_d;
      len_q <= len_d;
      sh_q  <= sh_d;
      gap_q <= gap_d;
    end
  end

  assign ready   = !act_q && (gap_q == '0);
  assign fin     = fin_q;
  assign rx_last = rx_q;
  assign sck     = sck_q;
  assign cs_n    = cs_q;
  assign mosi    = act_q & sh_q[FRAME_W-1];

endmodule

// File: rtl/fes_poll_budget.sv
module fes_poll_budget #(
  parameter int PLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  input  logic [PLW-1:0] limit,
  output logic           spent
);

  logic [PLW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // true when the poll now finishing is the last one allowed (limit 0 acts as 1)
  assign spent = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int DIV = 4,
  parameter int GAP = 2,
  parameter int PLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_block,
  input  logic           req_alt,
  input  logic [23:0]    req_addr,
  input  logic [PLW-1:0] poll_limit,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           sck,
  output logic           cs_n,
  output logic           mosi,
  input  logic           miso
);

  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  seq_state_t     st_q, st_d;
  logic [23:0]    addr_q, addr_d;
  logic           blk_q, blk_d;
  logic           alt_q, alt_d;
  logic [PLW-1:0] lim_q, lim_d;
  logic           done_q, done_d;
  logic           err_q, err_d;

  logic               fr_start, fr_ready, fr_fin, fr_rx;
  logic [NBITS_W-1:0] fr_nbits;
  logic [FRAME_W-1:0] fr_tx;
  logic               pb_clr, pb_inc, pb_spent;
  logic [7:0]         ers_opc;

  assign ers_opc = !blk_q ? OPC_SECTOR : (alt_q ? OPC_BLOCK_B : OPC_BLOCK_A);

  always_comb begin
    case (st_q)
      SEQ_WEN_GO: begin
        fr_nbits = NBITS_W'(8);
        fr_tx    = {OPC_WEN, 24'h0};
      end
      SEQ_ERS_GO: begin
        fr_nbits = NBITS_W'(32);
        fr_tx    = {ers_opc, addr_q};
      end
      default: begin
        fr_nbits = NBITS_W'(16);
        fr_tx    = {OPC_STATUS, 24'h0};
      end
    endcase
  end

  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    blk_d    = blk_q;
    alt_d    = alt_q;
    lim_d    = lim_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    fr_start = 1'b0;
    pb_clr   = 1'b0;
    pb_inc   = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          addr_d = req_addr;
          blk_d  = req_block;
          alt_d  = req_alt;
          lim_d  = poll_limit;
          st_d   = SEQ_WEN_GO;
        end
      end
      SEQ_WEN_GO: begin
        if (fr_ready) begin
          fr_start = 1'b1;
          st_d     = SEQ_WEN_WT;
        end
      end
      SEQ_WEN_WT: begin
        if (fr_fin) st_d = SEQ_ERS_GO;
      end
      SEQ_ERS_GO: begin
        if (fr_ready) begin
          fr_start = 1'b1;
          st_d     = SEQ_ERS_WT;
        end
      end
      SEQ_ERS_WT: begin
        if (fr_fin) begin
          pb_clr = 1'b1;
          st_d   = SEQ_POL_GO;
        end
      end
      SEQ_POL_GO: begin
        if (fr_ready) begin
          fr_start = 1'b1;
          st_d     = SEQ_POL_WT;
        end
      end
      SEQ_POL_WT: begin
        if (fr_fin) begin
          if (!fr_rx) begin
            done_d = 1'b1;
            st_d   = SEQ_IDLE;
          end else if (pb_spent) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            st_d   = SEQ_IDLE;
          end else begin
            pb_inc = 1'b1;
            st_d   = SEQ_POL_GO;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= SEQ_IDLE;
      addr_q <= '0;
      blk_q  <= 1'b0;
      alt_q  <= 1'b0;
      lim_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      blk_q  <= blk_d;
      alt_q  <= alt_d;
      lim_q  <= lim_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  fes_frame_shifter #(.DIV(DIV), .GAP(GAP)) u_shift (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (fr_start),
    .nbits   (fr_nbits),
    .tx      (fr_tx),
    .miso    (miso),
    .ready   (fr_ready),
    .fin     (fr_fin),
    .rx_last (fr_rx),
    .sck     (sck),
    .cs_n    (cs_n),
    .mosi    (mosi)
  );

  fes_poll_budget #(.PLW(PLW)) u_budget (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (pb_clr),
    .inc   (pb_inc),
    .limit (lim_q),
    .spent (pb_spent)
  );

  assign busy = (st_q != SEQ_IDLE);
  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic sck,
  input logic cs_n,
  input logic mosi
);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                         // R2
  AST_BUSY_FALLS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                   // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                         // R2
  AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);                                           // R9
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);                                          // R6
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));                  // R6
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);                                   // R8

endmodule

bind flash_erase_seq flash_erase_seq_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .busy (busy),
  .done (done),
  .err  (err),
  .sck  (sck),
  .cs_n (cs_n),
  .mosi (mosi)
);

// File: tb/flash_erase_seq_test.sv
`timescale 1ns/1ps
module flash_erase_seq_test;

  localparam int DIV = 4;
  localparam int PLW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_block = 1'b0;
  logic           req_alt = 1'b0;
  logic [23:0]    req_addr = '0;
  logic [PLW-1:0] poll_limit = '0;
  logic           busy, done, err, sck, cs_n, mosi;
  logic           miso = 1'b0;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.DIV(DIV), .GAP(2), .PLW(PLW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
    .req_alt(req_alt), .req_addr(req_addr), .poll_limit(poll_limit),
    .busy(busy), .done(done), .err(err), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  int n_cmp = 0;
  int n_mis = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model
  logic [39:0] cap = '0;
  int          nb = 0;
  int          nfr = 0;
  int          fr_bits [0:15];
  logic [39:0] fr_data [0:15];
  int          busy_left = 0;
  int          plan_busy = 0;
  bit          wel = 0;
  logic [7:0]  status_b;

  assign status_b = {6'b0, wel, (busy_left > 0)};

  always @(posedge sck) if (!cs_n) begin
    cap = {cap[38:0], mosi};
    nb  = nb + 1;
  end

  always @(negedge sck) if (!cs_n) begin
    if (nb >= 8 && nb <= 15) miso = status_b[15 - nb];
  end

  always @(posedge cs_n) begin
    if (nfr < 16) begin
      fr_bits[nfr] = nb;
      fr_data[nfr] = cap;
    end
    nfr = nfr + 1;
    if (nb == 8 && cap[7:0] == 8'h06) wel = 1;
    else if (nb == 32 && wel) begin
      busy_left = plan_busy;
      wel = 0;
    end else if (nb == 16 && cap[15:8] == 8'h05 && busy_left > 0)
      busy_left = busy_left - 1;
    nb = 0;
    cap = '0;
    miso = 1'b0;
  end

  // R6, R7, R8 monitors, sampled on the falling system clock edge
  int  hi_len = 0;
  int  cs_hi = 0;
  bit  prev_cs = 1'b1;
  logic prev_mosi = 1'b0;
  bit  prev_sck = 1'b0;
  bit  mon_on = 0;

  always @(negedge clk) if (mon_on) begin
    if (cs_n) chk(!sck, "R6 sck low while deselected", sck, 0);
    if (sck && prev_sck) chk(mosi == prev_mosi, "R6 mosi held while sck high", mosi, prev_mosi);
    if (sck) hi_len++;
    else if (hi_len != 0) begin
      chk(hi_len == DIV/2, "R7 sck high width", hi_len, DIV/2);
      hi_len = 0;
    end
    if (cs_n) cs_hi++;
    else if (prev_cs) begin
      chk(cs_hi >= 2, "R8 deselect gap", cs_hi, 2);
      cs_hi = 0;
    end
    prev_cs   = cs_n;
    prev_sck  = sck;
    prev_mosi = mosi;
  end

  task automatic run_op(input bit blk, input bit alt, input logic [23:0] a,
                        input int bp, input int lim, input bit poke);
    int eff, npoll, cyc;
    bit exp_err, busy_bad;
    logic [7:0] opc;
    eff     = (lim == 0) ? 1 : lim;
    exp_err = (bp >= eff);
    npoll   = exp_err ? eff : bp + 1;
    opc     = !blk ? 8'h20 : (alt ? 8'hD8 : 8'h52);
    plan_busy = bp;
    nfr = 0;
    req_block = blk; req_alt = alt; req_addr = a; poll_limit = PLW'(lim);
    @(negedge clk) req_valid = 1'b1;
    @(negedge clk) req_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    cyc = 0; busy_bad = 0;
    while (!done && cyc < 5000) begin
      if (!busy) busy_bad = 1;
      if (poke && cyc == 7) begin
        // R10: different request while busy must be ignored
        req_block = ~blk; req_alt = ~alt; req_addr = ~a; poll_limit = PLW'(9);
        req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
        req_block = blk; req_alt = alt; req_addr = a; poll_limit = PLW'(lim);
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(done == 1'b1, "R2 done reached", done, 1);
    chk(!busy_bad, "R2 busy held until done", busy_bad, 0);
    chk(busy == 1'b0, "R2 busy low at done", busy, 0);
    chk(err == exp_err, "R9 err at done", err, exp_err);
    chk(nfr == 2 + npoll, poke ? "R10 frame count with ignored request" : "R5 frame count",
        nfr, 2 + npoll);
    chk(fr_bits[0] == 8 && fr_data[0][7:0] == 8'h06, "R3 write-enable frame",
        {fr_bits[0], fr_data[0][7:0]}, {8, 8'h06});
    chk(fr_bits[1] == 32 && fr_data[1][31:0] == {opc, a}, "R4 erase frame",
        fr_data[1][31:0], {opc, a});
    for (int i = 2; i < 2 + npoll && i < 16; i++)
      chk(fr_bits[i] == 16 && fr_data[i][15:0] == 16'h0500, "R5 status frame",
          {fr_bits[i], fr_data[i][15:0]}, {16, 16'h0500});
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", done, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_mis++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    chk(sck == 1'b0, "R1 sck in reset", sck, 0);
    chk({busy, done, err} == 3'b000, "R1 status in reset", {busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;
    k = 0;
    for (int blk = 0; blk < 2; blk++)
      for (int alt = 0; alt < 2; alt++)
        for (int bp = 0; bp < 4; bp++)
          for (int lim = 0; lim < 5; lim++) begin
            run_op(blk[0], alt[0], (24'(k) * 24'h1357A9) ^ 24'hA5C35A, bp, lim, (k % 3) == 0);
            k++;
          end
    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule